// File: doc/BRIEF.md
# Glyph Segment Assembler

This block builds the dot pattern for one digit of a multiplexed 5x7 dot-matrix display. It keeps three small stores. The first maps each of 16 digit positions to an 8-bit character code. The second holds 8 user-defined 35-dot glyphs. The third holds a 2-bit symbol field for each digit position. A command decoder fills the stores through pointer-load and data-write strobes. A digit scan timer supplies the current digit index and a pulse that marks the start of each digit slot.

On each slot-start pulse the block reads the code for the indexed digit. Codes below 8 select a user glyph. Every other code selects a built-in glyph table, which here is a parameterised stub with a fill that can be computed. The 35 dot bits and the digit's 2 symbol bits are registered, so they change at the same time as the grid.

Top module: `glyph_seg_asm`

## Requirements
- R1: While rst_ni is low, and after its release until the first slot-start pulse, seg_o and sym_o are all zero.
- R2: code_ld_i loads cmd_addr_i into the code pointer. Each code_wr_i stores data_i into the code entry at the pointer, then advances the pointer. The pointer wraps from 15 to 0.
- R3: A character code from 0x00 to 0x07 makes seg_o show user glyph entry number `code`.
- R4: A character code from 0x08 to 0xFF makes seg_o show the built-in glyph. With default parameters, dot bit k of that glyph equals bit (k mod 8) of the code.
- R5: A glyph column write with column counter j (0 to 4) puts data_i bit r (r = 0 to 6) into dot C[j+5r] of the entry at the glyph pointer. data_i bit 7 has no effect, and the dots of the other columns keep their values.
- R6: pat_ld_i loads cmd_addr_i[2:0] into the glyph pointer and clears the column counter to 0. Each column write advances the column counter. After the write of column 4, the column counter returns to 0 and the glyph pointer advances, wrapping from 7 to 0.
- R7: sym_ld_i and sym_wr_i work on the symbol store in the same way as R2, and only data_i[1:0] is stored. sym_o shows the stored symbol field of the scanned digit directly, without any glyph lookup.
- R8: seg_o and sym_o change only on the clock edge where slot_start_i is high. They hold their values in every other cycle, including cycles in which the stores are written.
- R9: Dot Ck of the selected glyph drives seg_o[k]. Digit index n reads code entry n and symbol entry n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_addr_i | input | 4 | Address for a pointer load |
| data_i | input | 8 | Data byte for a store write |
| code_ld_i | input | 1 | Load the code pointer |
| code_wr_i | input | 1 | Write a code at the pointer, then advance the pointer |
| pat_ld_i | input | 1 | Load the glyph pointer and clear the column counter |
| pat_wr_i | input | 1 | Write one glyph column byte |
| sym_ld_i | input | 1 | Load the symbol pointer |
| sym_wr_i | input | 1 | Write a symbol field at the pointer, then advance the pointer |
| digit_idx_i | input | 4 | Index of the digit being scanned |
| slot_start_i | input | 1 | Start of the digit slot; captures the outputs |
| seg_o | output | 35 | Dot bits of the scanned digit |
| sym_o | output | 2 | Symbol bits of the scanned digit |

## Verification
Every store write takes effect at the clock edge where its strobe is high. The stores are read combinationally, so the written value can be seen at the next slot-start pulse. The outputs have a latency of exactly one edge: values presented with slot_start_i are registered at that edge. The bench drives inputs on falling edges and checks seg_o and sym_o at the falling edge after the capturing edge. For R8 it writes all three stores without a slot-start pulse and checks at the same point that both outputs are unchanged.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  localparam int unsigned DOT_COLS = 5;
  localparam int unsigned DOT_ROWS = 7;
  localparam int unsigned DOT_W    = DOT_COLS * DOT_ROWS;
  localparam int unsigned CODE_W   = 8;

  typedef logic [DOT_W-1:0] glyph_t;
endpackage

// File: rtl/gsb_ring_store.sv
module gsb_ring_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0]    ptr_q;
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (ld_i)  ptr_q <= addr_i;
    else if (wr_i)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  // contents undefined after reset
  always_ff @(posedge clk_i) begin
    if (wr_i && !ld_i) mem_q[ptr_q] <= data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  a_r2_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ld_i && ptr_q == LAST) |=> ptr_q == '0);
  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ld_i && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> ptr_q == $past(addr_i));
endmodule

// File: rtl/gsb_glyph_store.sv
module gsb_glyph_store
  import gsb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned AW     = $clog2(ENTRIES),
  localparam int unsigned CW     = $clog2(DOT_COLS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                wr_i,
  input  logic [DOT_ROWS-1:0] col_i,
  input  logic [AW-1:0]       rd_addr_i,
  output glyph_t              rd_glyph_o
);
  localparam logic [AW-1:0] LAST_ENT = AW'(ENTRIES - 1);
  localparam logic [CW-1:0] LAST_COL = CW'(DOT_COLS - 1);

  logic [AW-1:0] ptr_q;
  logic [CW-1:0] col_q;
  glyph_t        mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      col_q <= '0;
    end else if (ld_i) begin
      ptr_q <= addr_i;
      col_q <= '0;
    end else if (wr_i) begin
      if (col_q == LAST_COL) begin
        col_q <= '0;
        ptr_q <= (ptr_q == LAST_ENT) ? '0 : ptr_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // column byte scatters down one dot column: row r lands at col + DOT_COLS*r
  always_ff @(posedge clk_i) begin
    if (wr_i && !ld_i) begin
      for (int c = 0; c < DOT_COLS; c++) begin
        if (col_q == CW'(c)) begin
          for (int r = 0; r < DOT_ROWS; r++) begin
            mem_q[ptr_q][c + DOT_COLS*r] <= col_i[r];
          end
        end
      end
    end
  end

  assign rd_glyph_o = mem_q[rd_addr_i];

  a_r6_entry_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ld_i && col_q == LAST_COL) |=>
      (col_q == '0 && ptr_q == (($past(ptr_q) == LAST_ENT) ? '0 : $past(ptr_q) + 1'b1)));
  a_r6_entry_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ld_i && col_q != LAST_COL) |=> ($stable(ptr_q) && col_q == $past(col_q) + 1'b1));
  a_r6_col_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> col_q == '0);
  a_r6_col_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= LAST_COL);
endmodule

// File: rtl/gsb_glyph_rom.sv
module gsb_glyph_rom
  import gsb_pkg::*;
#(
  parameter logic [CODE_W-1:0] FILL_XOR = '0
) (
  input  logic [CODE_W-1:0] code_i,
  output glyph_t            glyph_o
);
  logic [CODE_W-1:0] key;
  assign key = code_i ^ FILL_XOR;

  // stub fill: dot k follows key bit k mod CODE_W
  for (genvar k = 0; k < DOT_W; k++) begin : g_dot
    assign glyph_o[k] = key[k % CODE_W];
  end
endmodule

// File: rtl/glyph_seg_asm.sv
module glyph_seg_asm
  import gsb_pkg::*;
#(
  parameter int unsigned N_DIGITS   = 16,
  parameter int unsigned N_USER     = 8,
  parameter int unsigned SYM_W      = 2,
  parameter logic [CODE_W-1:0] ROM_FILL_XOR = '0,
  localparam int unsigned DAW       = $clog2(N_DIGITS),
  localparam int unsigned UAW       = $clog2(N_USER)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DAW-1:0]    cmd_addr_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              code_ld_i,
  input  logic              code_wr_i,
  input  logic              pat_ld_i,
  input  logic              pat_wr_i,
  input  logic              sym_ld_i,
  input  logic              sym_wr_i,
  input  logic [DAW-1:0]    digit_idx_i,
  input  logic              slot_start_i,
  output logic [DOT_W-1:0]  seg_o,
  output logic [SYM_W-1:0]  sym_o
);
  logic [CODE_W-1:0] cur_code;
  logic [SYM_W-1:0]  cur_sym;
  glyph_t            user_glyph, rom_glyph, sel_glyph;
  logic              is_user;

  gsb_ring_store #(.WIDTH(CODE_W), .DEPTH(N_DIGITS)) u_code_store (
    .clk_i, .rst_ni,
    .ld_i(code_ld_i), .addr_i(cmd_addr_i),
    .wr_i(code_wr_i), .data_i(data_i),
    .rd_addr_i(digit_idx_i), .rd_data_o(cur_code)
  );

  gsb_ring_store #(.WIDTH(SYM_W), .DEPTH(N_DIGITS)) u_sym_store (
    .clk_i, .rst_ni,
    .ld_i(sym_ld_i), .addr_i(cmd_addr_i),
    .wr_i(sym_wr_i), .data_i(data_i[SYM_W-1:0]),
    .rd_addr_i(digit_idx_i), .rd_data_o(cur_sym)
  );

  gsb_glyph_store #(.ENTRIES(N_USER)) u_glyph_store (
    .clk_i, .rst_ni,
    .ld_i(pat_ld_i), .addr_i(cmd_addr_i[UAW-1:0]),
    .wr_i(pat_wr_i), .col_i(data_i[DOT_ROWS-1:0]),
    .rd_addr_i(cur_code[UAW-1:0]), .rd_glyph_o(user_glyph)
  );

  gsb_glyph_rom #(.FILL_XOR(ROM_FILL_XOR)) u_glyph_rom (
    .code_i(cur_code), .glyph_o(rom_glyph)
  );

  assign is_user   = cur_code < CODE_W'(N_USER);
  assign sel_glyph = is_user ? user_glyph : rom_glyph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_o <= '0;
      sym_o <= '0;
    end else if (slot_start_i) begin
      seg_o <= sel_glyph;
      sym_o <= cur_sym;
    end
  end

  a_r8_seg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start_i |=> $stable(seg_o));
  a_r8_sym_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start_i |=> $stable(sym_o));
  a_r7_sym_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_i |=> sym_o == $past(cur_sym));
  a_r3_user_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_i && is_user) |=> seg_o == $past(user_glyph));
  a_r4_rom_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_i && !is_user) |=> seg_o == $past(rom_glyph));
endmodule

// File: tb/glyph_seg_asm_tb.sv
module glyph_seg_asm_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  cmd_addr = 0;
  logic [7:0]  data = 0;
  logic        code_ld = 0, code_wr = 0, pat_ld = 0, pat_wr = 0;
  logic        sym_ld = 0, sym_wr = 0, slot = 0;
  logic [3:0]  didx = 0;
  logic [34:0] seg;
  logic [1:0]  sym;

  int vectors = 0, fails = 0;

  logic [7:0]  code_m [16];
  logic [1:0]  sym_m  [16];
  logic [34:0] pat_m  [8];
  int code_p = 0, sym_p = 0, pat_p = 0, pat_c = 0;

  always #5 clk = ~clk;

  glyph_seg_asm u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_addr_i(cmd_addr), .data_i(data),
    .code_ld_i(code_ld), .code_wr_i(code_wr), .pat_ld_i(pat_ld), .pat_wr_i(pat_wr),
    .sym_ld_i(sym_ld), .sym_wr_i(sym_wr), .digit_idx_i(didx), .slot_start_i(slot),
    .seg_o(seg), .sym_o(sym)
  );

  function automatic logic [34:0] expect_glyph(input logic [7:0] c);
    logic [34:0] g;
    if (c < 8) return pat_m[c[2:0]];
    for (int k = 0; k < 35; k++) g[k] = c[k % 8];
    return g;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    code_ld = 0; code_wr = 0; pat_ld = 0; pat_wr = 0;
    sym_ld = 0; sym_wr = 0; slot = 0;
  endtask

  task automatic code_load(input int a);
    @(negedge clk); cmd_addr = 4'(a); code_ld = 1; code_p = a; pulse_clear();
  endtask
  task automatic code_write(input logic [7:0] v);
    @(negedge clk); data = v; code_wr = 1;
    code_m[code_p] = v; code_p = (code_p + 1) % 16; pulse_clear();
  endtask
  task automatic sym_load(input int a);
    @(negedge clk); cmd_addr = 4'(a); sym_ld = 1; sym_p = a; pulse_clear();
  endtask
  task automatic sym_write(input logic [7:0] v);
    @(negedge clk); data = v; sym_wr = 1;
    sym_m[sym_p] = v[1:0]; sym_p = (sym_p + 1) % 16; pulse_clear();
  endtask
  task automatic pat_load(input int a);
    @(negedge clk); cmd_addr = 4'(a); pat_ld = 1; pat_p = a; pat_c = 0; pulse_clear();
  endtask
  task automatic pat_write(input logic [7:0] v);
    @(negedge clk); data = v; pat_wr = 1;
    for (int r = 0; r < 7; r++) pat_m[pat_p][pat_c + 5*r] = v[r];
    pat_c++;
    if (pat_c == 5) begin pat_c = 0; pat_p = (pat_p + 1) % 8; end
    pulse_clear();
  endtask

  // capture at the edge inside the pulse, check at the following falling edge
  task automatic show(input int d, input string req);
    @(negedge clk); didx = 4'(d); slot = 1; pulse_clear();
    chk(req, 64'(seg), 64'(expect_glyph(code_m[d])));
    chk("R7", 64'(sym), 64'(sym_m[d]));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset seg", 64'(seg), 64'd0);
    chk("R1 reset sym", 64'(sym), 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 post-reset seg", 64'(seg), 64'd0);
    chk("R1 post-reset sym", 64'(sym), 64'd0);

    // R5 R6: fill all 8 user glyphs plus one more entry; the pointer wraps to 0; bit 7 is set often
    pat_load(0);
    for (int i = 0; i < 45; i++) pat_write(8'((i * 37 + 11) ^ 8'h80));

    // R2: fill codes from 0, then two extra writes wrap to entries 0 and 1
    code_load(0);
    for (int i = 0; i < 16; i++) code_write(8'(i < 8 ? i : i * 29 + 3));
    code_write(8'h07);
    code_write(8'hA5);

    // R7: symbol fill starting mid-store, wrapping
    sym_load(5);
    for (int i = 0; i < 18; i++) sym_write(8'(i * 7 + 2));

    for (int d = 0; d < 16; d++) show(d, "R9 digit sweep");

    // R3 R4: every code through digit 3
    for (int c = 0; c < 256; c++) begin
      code_load(3);
      code_write(8'(c));
      show(3, c < 8 ? "R3 user code" : "R4 rom code");
    end

    // R6: a pointer load partway through an entry clears the column counter
    pat_load(2);
    pat_write(8'hFF);
    pat_write(8'hFF);
    pat_load(2);
    for (int j = 0; j < 5; j++) pat_write(8'(8'h15 << j));
    code_load(9);
    code_write(8'h02);
    show(9, "R6 column restart");
    // R5: bit 7 only, in all five columns, clears glyph 2
    pat_load(2);
    for (int j = 0; j < 5; j++) pat_write(8'h80);
    show(9, "R5 bit7 ignored");
    chk("R5 bit7 zero glyph", 64'(seg), 64'd0);

    // R8: write all three stores without a slot pulse; the outputs hold
    begin
      logic [34:0] seg_hold;
      logic [1:0]  sym_hold;
      seg_hold = seg; sym_hold = sym;
      pat_load(2); for (int j = 0; j < 5; j++) pat_write(8'h7F);
      code_load(9); code_write(8'h55);
      sym_load(9); sym_write(8'h03);
      repeat (3) @(negedge clk);
      chk("R8 seg hold", 64'(seg), 64'(seg_hold));
      chk("R8 sym hold", 64'(sym), 64'(sym_hold));
      show(9, "R8 update on slot");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule